// File: doc/BRIEF.md
# Grouped Change-of-State Interrupt Controller

This block watches 32 digital inputs, arranged as three 8-bit isolated input groups and one 8-bit TTL group. Each input passes through a two-flop synchronizer. The block compares the synchronized value with its value from the previous cycle to find rising and falling edges. An 8-bit arming register sets the edge polarity for each group of eight: one bit enables rising-edge capture for a group and another bit enables falling-edge capture for the same group. When an edge matches an armed polarity, the block sets a sticky event bit for that input. A single level interrupt stays high while any event bit is set.

Software reaches everything over a byte-wide register port. It reads and writes 24 output latches and reads the synchronized input levels. It reads the event bits and clears them by writing back the value it read, to the same byte addresses. A 1 written to an event bit clears it and a 0 leaves it alone.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `out_latch` is zero, `irq` is low and no edge is armed.
- R2: Byte addresses 0x0, 0x1 and 0x2 are read/write output latches. Byte b drives `out_latch[8b+7:8b]`.
- R3: Read-only addresses 0x4, 0x5 and 0x6 return bytes 0 to 2 of `iso_in`, and 0x7 returns `ttl_in`. The value returned is the synchronized level, two clocks behind the pins.
- R4: The arming register at 0xE is read/write. Bit g (g=0..3) arms rising edges of group g and bit 4+g arms falling edges of group g. Groups 0 to 2 are `iso_in` bytes 0 to 2 and group 3 is `ttl_in`. The register changes only when it is written.
- R5: A rising edge on an input whose group has its rising bit armed sets that input's event bit. The bit is set on the third clock edge after the pin changes.
- R6: A falling edge on an input whose group has its falling bit armed sets that input's event bit, with the same timing as R5.
- R7: An edge whose polarity is not armed for its group leaves the event bits unchanged.
- R8: The event bits read at 0x8 to 0xA (`iso_in` bytes 0 to 2) and at 0xB (`ttl_in`). A write to one of these addresses clears each bit written as 1. Bits written as 0 keep their value, and event bits never clear by themselves.
- R9: When a new event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R10: `irq` is high exactly while at least one event bit is set. It falls only after a clear write.
- R11: `bus_rdata` loads the addressed register on the clock edge where `bus_rd` is high and holds its value otherwise. Unmapped addresses (0x3, 0xC, 0xD, 0xF) read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iso_in | input | 24 | Isolated input lines, groups 0 to 2 |
| ttl_in | input | 8 | TTL input lines, group 3 |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_latch | output | 24 | Output latch contents |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is R9, where a clear write and a fresh edge on the same bit meet in the same clock. The bench first leaves a bit set from an earlier rising edge and arms both polarities for its group. It then drives the pin low and times a write-back clear so that the clear lands exactly on the third clock edge after the pin change, when the new falling edge is recorded. A behavioural model runs alongside every clock. The model tracks a queue of past pin samples, so any error in synchronizer depth or in clear-versus-set priority shows up as a mismatch on `irq` or on the read data.

// File: rtl/cos_pkg.sv
package cos_pkg;
  parameter int GRP_W     = 8;
  parameter int N_GRP     = 4;
  parameter int N_ISO_GRP = 3;
  parameter int ADDR_W    = 4;

  localparam int N_IN  = GRP_W * N_GRP;
  localparam int N_ISO = GRP_W * N_ISO_GRP;
  localparam int N_TTL = N_IN - N_ISO;
  localparam int EN_W  = 2 * N_GRP;

  localparam int ADR_OUT  = 0;
  localparam int ADR_IN   = 4;
  localparam int ADR_STAT = 8;
  localparam int ADR_ARM  = 14;

  typedef logic [N_IN-1:0] in_vec_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync
  import cos_pkg::*;
#(
  parameter int W = N_IN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dsync,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign dsync = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/cos_status.sv
module cos_status
  import cos_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  in_vec_t         rise,
  input  in_vec_t         fall,
  input  logic [EN_W-1:0] arm,
  input  in_vec_t         clr,
  output in_vec_t         stat
);
  in_vec_t set_v, stat_q, stat_nxt;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign set_v[g*GRP_W +: GRP_W] =
        (rise[g*GRP_W +: GRP_W] & {GRP_W{arm[g]}}) |
        (fall[g*GRP_W +: GRP_W] & {GRP_W{arm[N_GRP+g]}});
  end

  always_comb begin
    stat_nxt = (stat_q & ~clr) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  assign stat = stat_q;

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr & ~set_v)) == '0));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q & ~clr) & ~stat_q) == '0));
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_v) & ~stat_q) == '0));
  assert_no_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(rise | fall)) == '0));
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [GRP_W-1:0]  bus_wdata,
  input  in_vec_t           dsync,
  input  in_vec_t           stat,
  output logic [GRP_W-1:0]  bus_rdata,
  output logic [N_ISO-1:0]  out_q,
  output logic [EN_W-1:0]   arm_q,
  output in_vec_t           clr
);
  logic [N_ISO-1:0] out_nxt;
  logic [EN_W-1:0]  arm_nxt;
  logic [GRP_W-1:0] rd_q, rd_nxt;
  logic             out_ce, arm_ce;

  for (genvar b = 0; b < N_GRP; b++) begin : g_clr
    assign clr[b*GRP_W +: GRP_W] =
        (bus_wr && bus_addr == ADDR_W'(ADR_STAT + b)) ? bus_wdata : '0;
  end

  always_comb begin
    out_nxt = out_q;
    out_ce  = 1'b0;
    for (int b = 0; b < N_ISO_GRP; b++) begin
      if (bus_wr && bus_addr == ADDR_W'(ADR_OUT + b)) begin
        out_nxt[b*GRP_W +: GRP_W] = bus_wdata;
        out_ce = 1'b1;
      end
    end
    arm_ce  = bus_wr && (bus_addr == ADDR_W'(ADR_ARM));
    arm_nxt = bus_wdata;
  end

  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < N_ISO_GRP; b++) begin
      if (bus_addr == ADDR_W'(ADR_OUT + b)) rd_nxt = out_q[b*GRP_W +: GRP_W];
    end
    for (int b = 0; b < N_GRP; b++) begin
      if (bus_addr == ADDR_W'(ADR_IN + b))   rd_nxt = dsync[b*GRP_W +: GRP_W];
      if (bus_addr == ADDR_W'(ADR_STAT + b)) rd_nxt = stat[b*GRP_W +: GRP_W];
    end
    if (bus_addr == ADDR_W'(ADR_ARM)) rd_nxt = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      arm_q <= '0;
      rd_q  <= '0;
    end else begin
      if (out_ce) out_q <= out_nxt;
      if (arm_ce) arm_q <= arm_nxt;
      if (bus_rd) rd_q  <= rd_nxt;
    end
  end

  assign bus_rdata = rd_q;

  assert_arm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(ADR_ARM)) |=> $stable(arm_q));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ISO-1:0]  iso_in,
  input  logic [N_TTL-1:0]  ttl_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [GRP_W-1:0]  bus_wdata,
  output logic [GRP_W-1:0]  bus_rdata,
  output logic [N_ISO-1:0]  out_latch,
  output logic              irq
);
  in_vec_t         dsync, rise, fall, stat, clr;
  logic [EN_W-1:0] arm;

  cos_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ttl_in, iso_in}),
    .dsync(dsync), .rise(rise), .fall(fall)
  );

  cos_status u_status (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .arm(arm), .clr(clr), .stat(stat)
  );

  cos_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .dsync(dsync), .stat(stat),
    .bus_rdata(bus_rdata), .out_q(out_latch), .arm_q(arm), .clr(clr)
  );

  assign irq = |stat;

  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(bus_wr) && $past(bus_addr) >= ADDR_W'(ADR_STAT)
                    && $past(bus_addr) < ADDR_W'(ADR_STAT + N_GRP)));
endmodule

// File: tb/cos_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cos_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] iso_in = '0;
  logic [7:0]  ttl_in = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] out_latch;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cos_irq_ctrl u_cos_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .iso_in(iso_in), .ttl_in(ttl_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_latch(out_latch),
    .irq(irq)
  );

  // behavioural reference model
  bit [31:0] hist[$] = '{32'h0, 32'h0, 32'h0};
  bit [31:0] m_stat = '0;
  bit [23:0] m_out = '0;
  bit [7:0]  m_arm = '0, m_rd = '0;

  function automatic bit [7:0] m_read(input int a, input bit [31:0] lvl);
    if (a <= 2) return m_out[a*8 +: 8];
    if (a >= 4 && a <= 7) return lvl[(a-4)*8 +: 8];
    if (a >= 8 && a <= 11) return m_stat[(a-8)*8 +: 8];
    if (a == 14) return m_arm;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0, 32'h0};
      m_stat = '0; m_out = '0; m_arm = '0; m_rd = '0;
    end else begin
      bit [31:0] nstat, lvl, old;
      int a;
      lvl = hist[1];
      old = hist[2];
      a = int'(bus_addr);
      nstat = m_stat;
      if (bus_wr && a >= 8 && a <= 11)
        for (int k = 0; k < 8; k++) if (bus_wdata[k]) nstat[(a-8)*8+k] = 1'b0;
      for (int i = 0; i < 32; i++) begin
        int g;
        g = i / 8;
        if (lvl[i] && !old[i] && m_arm[g])   nstat[i] = 1'b1;
        if (!lvl[i] && old[i] && m_arm[4+g]) nstat[i] = 1'b1;
      end
      if (bus_rd) m_rd = m_read(a, lvl);
      if (bus_wr && a <= 2) m_out[a*8 +: 8] = bus_wdata;
      if (bus_wr && a == 14) m_arm = bus_wdata;
      m_stat = nstat;
      hist.push_front({ttl_in, iso_in});
      void'(hist.pop_back());
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 irq vs model", {31'h0, irq}, {31'h0, |m_stat});
      check("R11 rdata vs model", {24'h0, bus_rdata}, {24'h0, m_rd});
      check("R2 out_latch vs model", {8'h0, out_latch}, {8'h0, m_out});
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(posedge clk); #1;
    bus_addr = 4'(a); bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 out_latch", {8'h0, out_latch}, 32'h0);
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      check("R1 reg reset", {24'h0, v}, 32'h0);
    end
    // R11 unmapped addresses
    rd(3, v);  check("R11 unmapped 0x3", {24'h0, v}, 32'h0);
    rd(13, v); check("R11 unmapped 0xD", {24'h0, v}, 32'h0);
    // R2 output latches
    wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hF0);
    check("R2 out_latch", {8'h0, out_latch}, 32'h00F03CA5);
    rd(1, v); check("R2 readback 0x1", {24'h0, v}, 32'h3C);
    // R3 synchronized inputs, R7 with nothing armed
    @(posedge clk); #1 iso_in = 24'h123456; ttl_in = 8'h9A;
    idle(3);
    rd(4, v); check("R3 iso byte0", {24'h0, v}, 32'h56);
    rd(6, v); check("R3 iso byte2", {24'h0, v}, 32'h12);
    rd(7, v); check("R3 ttl", {24'h0, v}, 32'h9A);
    rd(8, v); check("R7 no arm no event", {24'h0, v}, 32'h0);
    check("R7 irq low", {31'h0, irq}, 32'h0);
    // R4 arm: rise group0, fall group3
    wr(14, 8'h81);
    rd(14, v); check("R4 arm readback", {24'h0, v}, 32'h81);
    @(posedge clk); #1 iso_in = 24'h12FFFF; ttl_in = 8'h00;
    idle(4);
    rd(8, v);  check("R5 rise group0", {24'h0, v}, 32'hA9);
    rd(9, v);  check("R7 group1 rise unarmed", {24'h0, v}, 32'h0);
    rd(11, v); check("R6 fall group3", {24'h0, v}, 32'h9A);
    check("R10 irq high", {31'h0, irq}, 32'h1);
    // R8 partial write-back clear
    wr(8, 8'h09);
    rd(8, v); check("R8 partial clear", {24'h0, v}, 32'hA0);
    wr(8, 8'hA0);
    check("R10 irq held by ttl", {31'h0, irq}, 32'h1);
    wr(11, 8'h9A);
    check("R10 irq low after clears", {31'h0, irq}, 32'h0);
    // R9 set wins: rise leaves bit0 set, then a fall edge meets the clear
    wr(14, 8'h11);
    @(posedge clk); #1 iso_in[0] = 1'b0;
    idle(4);
    wr(8, 8'h01);
    @(posedge clk); #1 iso_in[0] = 1'b1;
    idle(4);
    rd(8, v); check("R9 setup bit0 set", {24'h0, v & 8'h01}, 32'h1);
    @(posedge clk); #1 iso_in[0] = 1'b0;
    @(posedge clk);
    wr(8, 8'h01);
    rd(8, v); check("R9 set wins over clear", {24'h0, v & 8'h01}, 32'h1);
    wr(8, 8'hFF);
    check("R10 irq clear", {31'h0, irq}, 32'h0);
    idle(4);
    finish_run();
  end
endmodule